// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a small configuration register file that sits behind two I/O ports. Software first writes a register index to the command port. It then makes one access, read or write, to the data port, and that access acts on the selected register. Each index is good for exactly one data access. A further data access without a new index write has no effect, and a read in that case returns FFh.

The file holds four control registers, four three-byte region descriptors and a bank of extended registers. The extended bank is reachable only while a map field in the fourth control register carries the code 0001. The file also holds two read-only identification bytes. A sticky lock bit, which only reset clears, freezes a few security fields whenever the SMM-active input is high. Every stored value also leaves the block on wide decoded outputs, so that neighbouring logic can use it directly.

Top module: `cfg_index_port`

## Requirements
- R1: A write to address CMD_PORT (default 0022h) latches io_wdata as the index. The next read or write at DATA_PORT (default 0023h) acts on that index. A read updates io_rdata one clock after the read strobe is sampled, and io_rdata holds its value between reads. Accesses to any other address change nothing.
- R2: An index is used up by one data-port access. A data-port read with no fresh index returns FFh, and a data-port write with no fresh index changes no register. A read of CMD_PORT returns FFh.
- R3: After reset, control registers C0h..C3h are 00h and the extended registers are 00h. Region 0 bytes C4h, C5h, C6h are 00h, 00h, 0Fh, and every other region byte is 00h. The lock and map outputs are low.
- R4: Reserved bits read as 0 and ignore writes. These are bits 7..5 of C1h and bit 0 of C2h. All other control bits can be written.
- R5: Bit 0 of C3h is the lock (lock_o). Writing 1 sets it. Writing 0 leaves it unchanged, in SMM or outside it. Only reset clears it.
- R6: While lock_o and smm_active are both high, writes leave bits 3..1 of C1h and bit 1 of C3h unchanged, and the other writable bits still change. Without SMM, or without the lock, those bits can be written.
- R7: map_open_o is high exactly when bits 7..4 of C3h equal 0001. While it is high, indices D0h..D0h+EXT_COUNT-1 read and write the extended registers. While it is low, those indices read FFh and writes to them are ignored.
- R8: Index FEh reads MODEL_ID. Index FFh reads {REV_ID, STEP_ID}, with the revision in bits 7..4. Writes to either index are ignored.
- R9: Indices that are not implemented read FFh, and writes to them change nothing. These are all indices below C0h, and the indices from D0h+EXT_COUNT through FDh.
- R10: Region k occupies indices C4h+3k, C4h+3k+1 and C4h+3k+2. They hold start address bits 31..24, start bits 23..16, and {start bits 15..12, size code}. region_flat[24k+23:24k] is those three bytes, with the first byte most significant. ctrl_flat[8i+7:8i] is register C0h+i.
- R11: When io_rd and io_wr are high in the same cycle, the write takes place and the read does not: io_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | IO_AW (16) | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| smm_active | input | 1 | System management mode is active |
| io_rdata | output | 8 | Read data, registered |
| ctrl_flat | output | 32 | Control registers C0h..C3h, C0h in the low byte |
| region_flat | output | NUM_REGIONS*24 (96) | Region descriptors, region 0 in the low bits |
| ext_flat | output | EXT_COUNT*8 (64) | Extended registers, D0h in the low byte |
| lock_o | output | 1 | Sticky lock bit |
| map_open_o | output | 1 | Extended range is open |

## Verification
A register write becomes visible on the decoded outputs at the clock edge that samples the data-port strobe. The bench drives each strobe for one cycle starting at a falling edge and checks the outputs at the next falling edge, half a cycle after the update. Read data comes out of a register, so it is due one edge after the read strobe, and the bench samples io_rdata at the same falling edge where it drops io_rd. The checker's lock, guard, stale-read and hold properties look exactly one cycle ahead with |=>, which matches this single register stage on every path.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int unsigned BYTE_W     = 8;
   localparam int unsigned CTRL_COUNT = 4;

   localparam logic [7:0] IDX_CTRL_BASE   = 8'hC0;
   localparam logic [7:0] IDX_REGION_BASE = 8'hC4;
   localparam logic [7:0] IDX_EXT_BASE    = 8'hD0;
   localparam logic [7:0] IDX_EXT_LAST    = 8'hFD;
   localparam logic [7:0] IDX_MODEL       = 8'hFE;
   localparam logic [7:0] IDX_REVISION    = 8'hFF;

   localparam int unsigned LOCK_REG     = 3;
   localparam logic [3:0]  MAP_OPEN_VAL = 4'b0001;

   // writable bits per control register (element 0 = C0h)
   localparam logic [CTRL_COUNT-1:0][7:0] CTRL_WMASK = {8'hFF, 8'hFE, 8'h1F, 8'hFF};
   // bits frozen while locked in system management mode
   localparam logic [CTRL_COUNT-1:0][7:0] CTRL_GUARD = {8'h02, 8'h00, 8'h0E, 8'h00};

   typedef logic [BYTE_W-1:0] cfg_byte_t;

   typedef struct packed {
      logic      wr;
      logic      rd;
      cfg_byte_t idx;
      cfg_byte_t wdata;
   } cfg_acc_t;

endpackage

// File: rtl/cfg_idx_tracker.sv
module cfg_idx_tracker
   import cfg_port_pkg::*;
#(
   parameter int unsigned IO_AW = 16,
   parameter logic [IO_AW-1:0] CMD_PORT  = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT = 16'h0023
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IO_AW-1:0] io_addr,
   input  cfg_byte_t        io_wdata,
   input  logic             io_wr,
   input  logic             io_rd,
   output cfg_acc_t         acc,
   output logic             port_rd,
   output cfg_byte_t        idx_q,
   output logic             idx_vld
);

   logic wr_eff, rd_eff, hit_cmd, hit_dat;

   assign wr_eff  = io_wr;
   assign rd_eff  = io_rd & ~io_wr;
   assign hit_cmd = (io_addr == CMD_PORT);
   assign hit_dat = (io_addr == DATA_PORT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q   <= '0;
         idx_vld <= 1'b0;
      end else if (wr_eff && hit_cmd) begin
         idx_q   <= io_wdata;
         idx_vld <= 1'b1;
      end else if ((wr_eff || rd_eff) && hit_dat) begin
         idx_vld <= 1'b0;
      end
   end

   always_comb begin
      acc.wr    = wr_eff & hit_dat & idx_vld;
      acc.rd    = rd_eff & hit_dat & idx_vld;
      acc.idx   = idx_q;
      acc.wdata = io_wdata;
   end

   assign port_rd = rd_eff & (hit_cmd | hit_dat);

endmodule

// File: rtl/cfg_ctrl_bank.sv
module cfg_ctrl_bank
   import cfg_port_pkg::*;
(
   input  logic                              clk,
   input  logic                              rst_n,
   input  cfg_acc_t                          acc,
   input  logic                              smm_active,
   output logic [CTRL_COUNT-1:0][BYTE_W-1:0] ctrl_q,
   output logic                              hit,
   output cfg_byte_t                         rdata
);

   localparam int unsigned SEL_W = $clog2(CTRL_COUNT);

   logic guard_on;
   assign guard_on = ctrl_q[LOCK_REG][0] & smm_active;

   for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_reg
      localparam logic [7:0] MY_IDX = IDX_CTRL_BASE + 8'(i);
      cfg_byte_t mask, merged, nxt;

      assign mask   = CTRL_WMASK[i] & ~(guard_on ? CTRL_GUARD[i] : 8'h00);
      assign merged = (ctrl_q[i] & ~mask) | (acc.wdata & mask);

      if (i == LOCK_REG) begin : g_lock
         // sticky: a 1 sets, only reset clears
         assign nxt = {merged[7:1], ctrl_q[i][0] | acc.wdata[0]};
      end else begin : g_plain
         assign nxt = merged;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            ctrl_q[i] <= '0;
         else if (acc.wr && (acc.idx == MY_IDX))
            ctrl_q[i] <= nxt;
      end
   end

   assign hit   = (acc.idx[7:SEL_W] == IDX_CTRL_BASE[7:SEL_W]);
   assign rdata = ctrl_q[acc.idx[SEL_W-1:0]];

endmodule

// File: rtl/cfg_region_bank.sv
module cfg_region_bank
   import cfg_port_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 4,
   parameter logic [3:0]  REG0_SIZE   = 4'hF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  cfg_acc_t                 acc,
   output logic [NUM_REGIONS*24-1:0] region_flat,
   output logic                     hit,
   output cfg_byte_t                rdata
);

   localparam int unsigned NB    = NUM_REGIONS * 3;
   localparam int unsigned OFF_W = $clog2(NB);

   if (NUM_REGIONS < 1 || NUM_REGIONS > 4) begin : g_bad_regions
      $error("cfg_region_bank: NUM_REGIONS must lie in 1..4");
   end

   cfg_byte_t       bytes_q [NB];
   logic [7:0]      off;

   assign off = acc.idx - IDX_REGION_BASE;
   assign hit = (acc.idx >= IDX_REGION_BASE) && (off < 8'(NB));

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam cfg_byte_t RST_VAL = (b == 2) ? {4'h0, REG0_SIZE} : 8'h00;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bytes_q[b] <= RST_VAL;
         else if (acc.wr && hit && (off[OFF_W-1:0] == OFF_W'(b)))
            bytes_q[b] <= acc.wdata;
      end
   end

   for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_pack
      assign region_flat[k*24 +: 24] = {bytes_q[3*k], bytes_q[3*k+1], bytes_q[3*k+2]};
   end

   assign rdata = hit ? bytes_q[off[OFF_W-1:0]] : 8'hFF;

endmodule

// File: rtl/cfg_ext_bank.sv
module cfg_ext_bank
   import cfg_port_pkg::*;
#(
   parameter int unsigned EXT_COUNT = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  cfg_acc_t               acc,
   input  logic                   map_open,
   output logic [EXT_COUNT*8-1:0] ext_flat,
   output logic                   hit,
   output cfg_byte_t              rdata
);

   localparam int unsigned EW = $clog2(EXT_COUNT);

   if (EXT_COUNT < 2 || EXT_COUNT > 46) begin : g_bad_ext
      $error("cfg_ext_bank: EXT_COUNT must lie in 2..46");
   end

   cfg_byte_t  ext_q [EXT_COUNT];
   logic [7:0] off;

   assign off = acc.idx - IDX_EXT_BASE;
   assign hit = map_open && (acc.idx >= IDX_EXT_BASE) && (off < 8'(EXT_COUNT));

   for (genvar j = 0; j < EXT_COUNT; j++) begin : g_ext
      always_ff @(posedge clk) begin
         if (!rst_n)
            ext_q[j] <= '0;
         else if (acc.wr && hit && (off[EW-1:0] == EW'(j)))
            ext_q[j] <= acc.wdata;
      end
      assign ext_flat[j*8 +: 8] = ext_q[j];
   end

   assign rdata = hit ? ext_q[off[EW-1:0]] : 8'hFF;

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int unsigned      IO_AW       = 16,
   parameter logic [IO_AW-1:0] CMD_PORT    = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT   = 16'h0023,
   parameter int unsigned      NUM_REGIONS = 4,
   parameter int unsigned      EXT_COUNT   = 8,
   parameter logic [7:0]       MODEL_ID    = 8'h1B,
   parameter logic [3:0]       REV_ID      = 4'h3,
   parameter logic [3:0]       STEP_ID     = 4'h1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IO_AW-1:0]         io_addr,
   input  logic [7:0]               io_wdata,
   input  logic                     io_wr,
   input  logic                     io_rd,
   input  logic                     smm_active,
   output logic [7:0]               io_rdata,
   output logic [31:0]              ctrl_flat,
   output logic [NUM_REGIONS*24-1:0] region_flat,
   output logic [EXT_COUNT*8-1:0]   ext_flat,
   output logic                     lock_o,
   output logic                     map_open_o
);

   if (CMD_PORT == DATA_PORT) begin : g_bad_ports
      $error("cfg_index_port: command and data ports must differ");
   end

   cfg_acc_t                          acc;
   logic                              port_rd;
   cfg_byte_t                         idx_q;
   logic                              idx_vld;
   logic [CTRL_COUNT-1:0][BYTE_W-1:0] ctrl_q;
   logic                              ctrl_hit, reg_hit, ext_hit;
   cfg_byte_t                         ctrl_rd, reg_rd, ext_rd, sel;

   cfg_idx_tracker #(
      .IO_AW(IO_AW), .CMD_PORT(CMD_PORT), .DATA_PORT(DATA_PORT)
   ) u_idx (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .acc(acc), .port_rd(port_rd),
      .idx_q(idx_q), .idx_vld(idx_vld)
   );

   cfg_ctrl_bank u_ctrl (
      .clk(clk), .rst_n(rst_n), .acc(acc), .smm_active(smm_active),
      .ctrl_q(ctrl_q), .hit(ctrl_hit), .rdata(ctrl_rd)
   );

   cfg_region_bank #(.NUM_REGIONS(NUM_REGIONS), .REG0_SIZE(4'hF)) u_region (
      .clk(clk), .rst_n(rst_n), .acc(acc), .region_flat(region_flat),
      .hit(reg_hit), .rdata(reg_rd)
   );

   assign map_open_o = (ctrl_q[LOCK_REG][7:4] == MAP_OPEN_VAL);
   assign lock_o     = ctrl_q[LOCK_REG][0];
   assign ctrl_flat  = ctrl_q;

   cfg_ext_bank #(.EXT_COUNT(EXT_COUNT)) u_ext (
      .clk(clk), .rst_n(rst_n), .acc(acc), .map_open(map_open_o),
      .ext_flat(ext_flat), .hit(ext_hit), .rdata(ext_rd)
   );

   always_comb begin
      if (ctrl_hit)                    sel = ctrl_rd;
      else if (reg_hit)                sel = reg_rd;
      else if (ext_hit)                sel = ext_rd;
      else if (acc.idx == IDX_MODEL)    sel = MODEL_ID;
      else if (acc.idx == IDX_REVISION) sel = {REV_ID, STEP_ID};
      else                             sel = 8'hFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         io_rdata <= 8'h00;
      else if (port_rd)
         io_rdata <= acc.rd ? sel : 8'hFF;
   end

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
   parameter int unsigned      IO_AW       = 16,
   parameter logic [IO_AW-1:0] CMD_PORT    = 16'h0022,
   parameter logic [IO_AW-1:0] DATA_PORT   = 16'h0023,
   parameter int unsigned      EXT_COUNT   = 8,
   parameter logic [7:0]       MODEL_ID    = 8'h1B
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [IO_AW-1:0]       io_addr,
   input logic                   io_wr,
   input logic                   io_rd,
   input logic                   smm_active,
   input logic [7:0]             io_rdata,
   input logic [31:0]            ctrl_flat,
   input logic [EXT_COUNT*8-1:0] ext_flat,
   input logic                   lock_o,
   input logic                   map_open_o,
   input logic [7:0]             idx_q,
   input logic                   idx_vld
);

   logic data_rd, any_port_rd;
   assign data_rd     = io_rd && !io_wr && (io_addr == DATA_PORT);
   assign any_port_rd = io_rd && !io_wr && ((io_addr == DATA_PORT) || (io_addr == CMD_PORT));

   p_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_wr || io_rd) && (io_addr == DATA_PORT)) |=> !idx_vld);

   p_stale_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !idx_vld) |=> (io_rdata == 8'hFF));

   p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_flat[15:13] == 3'b000) && (ctrl_flat[16] == 1'b0));

   p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |=> lock_o);

   p_smm_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && smm_active) |=>
         ((ctrl_flat[11:9] == $past(ctrl_flat[11:9])) && (ctrl_flat[25] == $past(ctrl_flat[25]))));

   p_ext_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !map_open_o |=> $stable(ext_flat));

   p_model_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && idx_vld && (idx_q == 8'hFE)) |=> (io_rdata == MODEL_ID));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !any_port_rd |=> $stable(io_rdata));

endmodule

bind cfg_index_port cfg_index_port_chk #(
   .IO_AW(IO_AW), .CMD_PORT(CMD_PORT), .DATA_PORT(DATA_PORT),
   .EXT_COUNT(EXT_COUNT), .MODEL_ID(MODEL_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .smm_active(smm_active), .io_rdata(io_rdata), .ctrl_flat(ctrl_flat),
   .ext_flat(ext_flat), .lock_o(lock_o), .map_open_o(map_open_o),
   .idx_q(idx_q), .idx_vld(idx_vld)
);

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;

   localparam logic [15:0] CMD  = 16'h0022;
   localparam logic [15:0] DAT  = 16'h0023;
   localparam int NREG = 4;
   localparam int NEXT = 8;
   localparam logic [7:0] MODEL = 8'h1B;
   localparam logic [7:0] REVB  = 8'h31;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0, smm_active = 1'b0;
   logic [7:0]  io_rdata;
   logic [31:0] ctrl_flat;
   logic [NREG*24-1:0] region_flat;
   logic [NEXT*8-1:0]  ext_flat;
   logic        lock_o, map_open_o;

   int tests = 0, fails = 0;
   bit done = 0;

   logic [7:0] m_ctrl [4];
   logic [7:0] m_reg  [NREG*3];
   logic [7:0] m_ext  [NEXT];

   always #10 clk = ~clk;

   cfg_index_port u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_rd(io_rd), .smm_active(smm_active), .io_rdata(io_rdata),
      .ctrl_flat(ctrl_flat), .region_flat(region_flat), .ext_flat(ext_flat),
      .lock_o(lock_o), .map_open_o(map_open_o)
   );

   task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic void mdl_reset();
      for (int i = 0; i < 4; i++) m_ctrl[i] = 8'h00;
      for (int i = 0; i < NREG*3; i++) m_reg[i] = 8'h00;
      m_reg[2] = 8'h0F;
      for (int i = 0; i < NEXT; i++) m_ext[i] = 8'h00;
   endfunction

   function automatic logic mdl_map();
      return m_ctrl[3][7:4] == 4'b0001;
   endfunction

   function automatic void mdl_write(input logic [7:0] idx, input logic [7:0] v, input logic smm);
      logic [7:0] msk;
      logic [7:0] old;
      if (idx >= 8'hC0 && idx <= 8'hC3) begin
         case (idx[1:0])
            2'd0: msk = 8'hFF;
            2'd1: msk = 8'h1F;
            2'd2: msk = 8'hFE;
            default: msk = 8'hFF;
         endcase
         if (m_ctrl[3][0] && smm) begin
            if (idx[1:0] == 2'd1) msk = msk & 8'hF1;
            if (idx[1:0] == 2'd3) msk = msk & 8'hFD;
         end
         old = m_ctrl[idx[1:0]];
         m_ctrl[idx[1:0]] = (old & ~msk) | (v & msk);
         if (idx[1:0] == 2'd3) m_ctrl[3][0] = old[0] | v[0];
      end else if (idx >= 8'hC4 && idx < 8'hC4 + 8'(NREG*3)) begin
         m_reg[idx - 8'hC4] = v;
      end else if (mdl_map() && idx >= 8'hD0 && idx < 8'hD0 + 8'(NEXT)) begin
         m_ext[idx - 8'hD0] = v;
      end
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] idx);
      if (idx >= 8'hC0 && idx <= 8'hC3) return m_ctrl[idx[1:0]];
      if (idx >= 8'hC4 && idx < 8'hC4 + 8'(NREG*3)) return m_reg[idx - 8'hC4];
      if (mdl_map() && idx >= 8'hD0 && idx < 8'hD0 + 8'(NEXT)) return m_ext[idx - 8'hD0];
      if (idx == 8'hFE) return MODEL;
      if (idx == 8'hFF) return REVB;
      return 8'hFF;
   endfunction

   task automatic check_state(input string req);
      logic [NREG*24-1:0] rg;
      logic [NEXT*8-1:0]  ex;
      for (int k = 0; k < NREG; k++) rg[k*24 +: 24] = {m_reg[3*k], m_reg[3*k+1], m_reg[3*k+2]};
      for (int j = 0; j < NEXT; j++) ex[j*8 +: 8] = m_ext[j];
      check(128'(ctrl_flat), 128'({m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]}), {req, " ctrl_flat"});
      check(128'(region_flat), 128'(rg), {req, " region_flat"});
      check(128'(ext_flat), 128'(ex), {req, " ext_flat"});
      check(128'({lock_o, map_open_o}), 128'({m_ctrl[3][0], mdl_map()}), {req, " lock/map"});
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = '0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0; io_addr = '0;
      d = io_rdata;
   endtask

   task automatic cfg_write(input logic [7:0] idx, input logic [7:0] v);
      io_write(CMD, idx);
      io_write(DAT, v);
      mdl_write(idx, v, smm_active);
   endtask

   task automatic cfg_read(input logic [7:0] idx, input string req);
      logic [7:0] d;
      io_write(CMD, idx);
      io_read(DAT, d);
      check(128'(d), 128'(exp_read(idx)), req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mdl_reset();
   endtask

   function automatic logic [7:0] pick_idx();
      int unsigned r;
      r = $urandom % 8;
      case (r)
         0, 1, 2: return 8'hC0 + 8'($urandom % 4);
         3, 4:    return 8'hC4 + 8'($urandom % (NREG*3));
         5:       return 8'hD0 + 8'($urandom % (NEXT + 2));
         6:       return 8'hFE + 8'($urandom % 2);
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, prev;
      void'($urandom(32'h00C0FFEE));
      mdl_reset();
      do_reset();

      // R3 reset state
      check_state("R3");
      check(128'(region_flat[23:0]), 128'(24'h00000F), "R3 region0 reset");
      cfg_read(8'hC6, "R3 region0 size byte");

      // R1 protocol and read latency, foreign address ignored
      cfg_write(8'hC0, 8'hA5);
      check_state("R1");
      io_write(CMD, 8'hC0);
      io_write(16'h0024, 8'hC4);
      io_read(DAT, d);
      check(128'(d), 128'(8'hA5), "R1 foreign address ignored");

      // R2 stale access
      io_write(DAT, 8'h3C);
      check_state("R2 stale write");
      io_read(DAT, d);
      check(128'(d), 128'(8'hFF), "R2 stale read");
      io_read(CMD, d);
      check(128'(d), 128'(8'hFF), "R2 command port read");

      // R4 reserved bits
      cfg_write(8'hC1, 8'hFF);
      cfg_read(8'hC1, "R4 C1 reserved");
      check(128'(ctrl_flat[15:8]), 128'(8'h1F), "R4 C1 value");
      cfg_write(8'hC2, 8'hFF);
      check(128'(ctrl_flat[23:16]), 128'(8'hFE), "R4 C2 value");

      // R5 / R6 lock behaviour
      cfg_write(8'hC3, 8'h03);
      check(128'(lock_o), 128'(1'b1), "R5 lock set");
      smm_active = 1'b1;
      cfg_write(8'hC1, 8'h00);
      check(128'(ctrl_flat[15:8]), 128'(8'h0E), "R6 guarded C1 in SMM");
      cfg_write(8'hC3, 8'h00);
      check(128'(ctrl_flat[31:24]), 128'(8'h03), "R6 guarded C3 in SMM, R5 lock kept");
      smm_active = 1'b0;
      cfg_write(8'hC1, 8'h00);
      check(128'(ctrl_flat[15:8]), 128'(8'h00), "R6 C1 writable outside SMM");
      cfg_write(8'hC3, 8'h00);
      check(128'(ctrl_flat[31:24]), 128'(8'h01), "R5 lock not cleared by write");

      // R7 map gating
      cfg_write(8'hD0, 8'hAA);
      check_state("R7 closed write");
      cfg_read(8'hD0, "R7 closed read");
      cfg_write(8'hC3, 8'h11);
      check(128'(map_open_o), 128'(1'b1), "R7 map opens");
      cfg_read(8'hD0, "R7 open read");
      cfg_write(8'hD3, 8'h5B);
      cfg_read(8'hD3, "R7 open write");
      cfg_read(8'hD0 + 8'(NEXT), "R9 beyond ext bank");
      cfg_write(8'hC3, 8'h21);
      cfg_read(8'hD3, "R7 reclosed read");

      // R8 identification
      cfg_read(8'hFE, "R8 model");
      cfg_read(8'hFF, "R8 revision");
      cfg_write(8'hFE, 8'h00);
      cfg_read(8'hFE, "R8 model write ignored");

      // R9 unimplemented
      cfg_write(8'h10, 8'h77);
      check_state("R9 write ignored");
      cfg_read(8'h10, "R9 read FF");

      // R10 region layout
      cfg_write(8'hC7, 8'h12);
      cfg_write(8'hC8, 8'h34);
      cfg_write(8'hC9, 8'h56);
      check(128'(region_flat[47:24]), 128'(24'h123456), "R10 region1 layout");

      // R11 simultaneous strobes
      io_read(CMD, prev);
      io_write(CMD, 8'hC0);
      @(negedge clk);
      io_addr = DAT; io_wdata = 8'h5A; io_wr = 1'b1; io_rd = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0; io_addr = '0;
      mdl_write(8'hC0, 8'h5A, smm_active);
      check(128'(io_rdata), 128'(prev), "R11 read suppressed");
      check_state("R11 write taken");

      // R5 reset clears lock
      do_reset();
      check_state("R5 after reset");

      // random phase
      for (int it = 0; it < 400; it++) begin
         logic [7:0] ix, v;
         int unsigned op;
         smm_active = 1'($urandom % 2);
         ix = pick_idx();
         v  = 8'($urandom);
         op = $urandom % 5;
         if (op < 2) begin
            cfg_write(ix, v);
            check_state("R6 random write");
         end else if (op < 4) begin
            cfg_read(ix, "R7 random read");
         end else if ($urandom % 2 == 0) begin
            io_write(DAT, v);
            check_state("R2 random stale write");
         end else begin
            io_read(DAT, d);
            check(128'(d), 128'(8'hFF), "R2 random stale read");
         end
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule